// File: doc/BRIEF.md
# Flow-Through Synchronous Burst Memory Core

This block is a synthesizable behavioural core of a flow-through synchronous burst memory. On a strobe cycle it registers an external address. It then walks a four-word burst by stepping the low address bits internally. Each word has four byte lanes, and each lane can be written on its own. There is no output pipeline: after the clock edge that sets the internal address, read data for that address is on the output port in the same cycle.

There are two address strobes. The processor-side strobe only loads an address and never writes in its own cycle. The controller-side strobe loads an address and can write to it in that same cycle. It also takes effect in the middle of a burst, which starts a fresh burst at the new address. In the cycles between strobes, an active-low step input chooses the address. When step is high, the internal address holds. When step is low, the address moves to the next word in the aligned group of four. A write in such a cycle lands on the address chosen for that cycle.

Three chip-enable inputs gate every strobe. The data bus is split into an input port, an output port and a drive-enable flag, which an external pad would use.

Top module: `burst_sram`

## Requirements
- R1: The chip is selected only when sel_a_n=0, sel_b_n=0 and sel_c=1. A strobe cycle without selection loads no address, writes nothing and leaves dq_oe low, and the cycles that follow it write nothing until a selected strobe.
- R2: Read data is flow-through. After the clock edge that sets the internal address, dq_out holds the word stored at that address, including a word written at that edge.
- R3: In a non-strobe cycle of an active burst with step_n=0, the low two address bits increment modulo 4 and the upper bits are kept. From base address B the sequence is B, B+1, B+2, B+3 and then B again.
- R4: In a non-strobe cycle with step_n=1, the internal address does not change.
- R5: In a cycle with proc_stb_n=0, all write inputs are ignored and only the address is loaded. proc_stb_n=0 takes priority over ctrl_stb_n=0.
- R6: With ctrl_stb_n=0 and proc_stb_n=1, a selected cycle loads addr. Any enabled write goes to addr in that cycle. This restarts the burst even mid-burst.
- R7: all_wr_n=0 writes all 36 bits whatever lane_en_n and lane_wr_n are. With all_wr_n=1, lane_en_n=0 and lane_wr_n=4'b0000, all 36 bits are also written.
- R8: With all_wr_n=1 and lane_en_n=0, only the lanes whose lane_wr_n bit is 0 are written. Lane i covers data bits [9i+8:9i]. With all_wr_n=1 and lane_en_n=1, nothing is written.
- R9: dq_oe is 0 whenever drive_en_n=1 or no burst is active, and 1 when drive_en_n=0 and a burst is active. Reset leaves no burst active.
- R10: A write in a non-strobe cycle goes to the held address when step_n=1, and to the stepped address when step_n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | External word address, sampled on strobe cycles |
| proc_stb_n | input | 1 | Processor-side address strobe, load only (active low) |
| ctrl_stb_n | input | 1 | Controller-side address strobe, load and write (active low) |
| step_n | input | 1 | Burst step: low steps, high holds |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| all_wr_n | input | 1 | Global full-word write (active low) |
| lane_en_n | input | 1 | Enable for per-lane writes (active low) |
| lane_wr_n | input | 4 | Per-lane write select, bit i for lane i (active low) |
| drive_en_n | input | 1 | Output drive enable (active low) |
| dq_in | input | 36 | Write data |
| dq_out | output | 36 | Read data for the current internal address |
| dq_oe | output | 1 | High when an external pad should drive dq_out |

## Verification
The assertions assume that all control inputs are stable and known at each rising edge. They also assume that reset is applied before the first strobe, so that the address and burst state start from known values. The bench changes every input one time unit after a rising edge and holds it until the next edge, so each cycle sees one clean command. The bench reads back only addresses that it wrote earlier, because the array itself has no reset.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int ADDR_W    = 8;
  localparam int LANES     = 4;
  localparam int LANE_W    = 9;
  localparam int STEP_BITS = 2;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_LOADP = 2'd1,
    CYC_LOADC = 2'd2,
    CYC_CONT  = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/burst_sram_addr_ctl.sv
module burst_sram_addr_ctl
  import burst_sram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SB = STEP_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          proc_stb_n,
  input  logic          ctrl_stb_n,
  input  logic          step_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] eff_addr,
  output cyc_kind_e     kind,
  output logic          active_q
);
  logic          strobe;
  logic [AW-1:0] stepped;

  assign strobe  = !proc_stb_n || !ctrl_stb_n;
  assign stepped = {addr_q[AW-1:SB], addr_q[SB-1:0] + SB'(1)};

  always_comb begin
    kind = CYC_IDLE;
    if (!proc_stb_n) begin
      if (sel) kind = CYC_LOADP;
    end else if (!ctrl_stb_n) begin
      if (sel) kind = CYC_LOADC;
    end else if (active_q) begin
      kind = CYC_CONT;
    end
  end

  always_comb begin
    unique case (kind)
      CYC_LOADC: eff_addr = addr_in;
      CYC_CONT:  eff_addr = step_n ? addr_q : stepped;
      default:   eff_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      active_q <= 1'b0;
    end else if (strobe) begin
      if (sel) begin
        addr_q   <= addr_in;
        active_q <= 1'b1;
      end else begin
        active_q <= 1'b0;
      end
    end else if (kind == CYC_CONT && !step_n) begin
      addr_q <= stepped;
    end
  end

  p_step_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_CONT && !step_n) |=>
      (addr_q[SB-1:0] == $past(addr_q[SB-1:0]) + SB'(1)) &&
      (addr_q[AW-1:SB] == $past(addr_q[AW-1:SB])))
    else $error("R3 step/wrap violated");

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (proc_stb_n && ctrl_stb_n && step_n) |=> $stable(addr_q))
    else $error("R4 hold violated");

  p_ctrl_load_r6: assert property (@(posedge clk) disable iff (rst)
    (sel && proc_stb_n && !ctrl_stb_n) |=> (addr_q == $past(addr_in)) && active_q)
    else $error("R6 load violated");

  p_desel_r1: assert property (@(posedge clk) disable iff (rst)
    (!sel && (!proc_stb_n || !ctrl_stb_n)) |=> !active_q)
    else $error("R1 deselect violated");
endmodule

// File: rtl/burst_sram_wr_decode.sv
module burst_sram_wr_decode #(
  parameter int LN = 4
) (
  input  logic          allow,
  input  logic          all_wr_n,
  input  logic          lane_en_n,
  input  logic [LN-1:0] lane_wr_n,
  output logic [LN-1:0] lane_we
);
  for (genvar i = 0; i < LN; i++) begin : g_lane
    assign lane_we[i] = allow && (!all_wr_n || (!lane_en_n && !lane_wr_n[i]));
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int AW = 8,
  parameter int LN = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic [LN-1:0]    we,
  input  logic [AW-1:0]    waddr,
  input  logic [LN*LW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [LN*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [LN*LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LN; l++) begin
      if (we[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LN = LANES,
  parameter int LW = LANE_W,
  parameter int SB = STEP_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             proc_stb_n,
  input  logic             ctrl_stb_n,
  input  logic             step_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             all_wr_n,
  input  logic             lane_en_n,
  input  logic [LN-1:0]    lane_wr_n,
  input  logic             drive_en_n,
  input  logic [LN*LW-1:0] dq_in,
  output logic [LN*LW-1:0] dq_out,
  output logic             dq_oe
);
  logic          sel;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] eff_addr;
  cyc_kind_e     kind;
  logic          active_q;
  logic          allow;
  logic [LN-1:0] lane_we;

  assign sel   = !sel_a_n && !sel_b_n && sel_c;
  assign allow = (kind == CYC_LOADC) || (kind == CYC_CONT);

  burst_sram_addr_ctl #(.AW(AW), .SB(SB)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .step_n     (step_n),
    .addr_in    (addr),
    .addr_q     (addr_q),
    .eff_addr   (eff_addr),
    .kind       (kind),
    .active_q   (active_q)
  );

  burst_sram_wr_decode #(.LN(LN)) u_dec (
    .allow     (allow),
    .all_wr_n  (all_wr_n),
    .lane_en_n (lane_en_n),
    .lane_wr_n (lane_wr_n),
    .lane_we   (lane_we)
  );

  burst_sram_array #(.AW(AW), .LN(LN), .LW(LW)) u_mem (
    .clk   (clk),
    .we    (lane_we),
    .waddr (eff_addr),
    .wdata (dq_in),
    .raddr (addr_q),
    .rdata (dq_out)
  );

  assign dq_oe = active_q && !drive_en_n;

  p_proc_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    !proc_stb_n |-> (lane_we == '0))
    else $error("R5 write during processor strobe");

  p_full_word_r7: assert property (@(posedge clk) disable iff (rst)
    (sel && proc_stb_n && !ctrl_stb_n && !all_wr_n) |-> ($countones(lane_we) == LN))
    else $error("R7 full write incomplete");

  p_desel_nowrite_r1: assert property (@(posedge clk) disable iff (rst)
    (!sel && (!proc_stb_n || !ctrl_stb_n)) |-> (lane_we == '0))
    else $error("R1 write while deselected");

  p_no_drive_r9: assert property (@(posedge clk) disable iff (rst)
    (!sel && (!proc_stb_n || !ctrl_stb_n)) |=> !dq_oe)
    else $error("R9 driving after deselect");
endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  addr;
  logic        proc_stb_n, ctrl_stb_n, step_n;
  logic        sel_a_n, sel_b_n, sel_c;
  logic        all_wr_n, lane_en_n;
  logic [3:0]  lane_wr_n;
  logic        drive_en_n;
  logic [35:0] dq_in, dq_out;
  logic        dq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  burst_sram u_burst_sram (
    .clk(clk), .rst(rst), .addr(addr), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .step_n(step_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .sel_c(sel_c), .all_wr_n(all_wr_n),
    .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n), .drive_en_n(drive_en_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  localparam logic [35:0] D0 = 36'h1_2345_6789, D1 = 36'h2_1111_0001,
                          D2 = 36'h3_2222_0002, D3 = 36'h4_3333_0003,
                          D4 = 36'h5_4444_0004, JUNK = 36'hD_EAD0_BEEF;

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // one command cycle: strobes, step, write controls, address, data
  task automatic cyc(input logic ps, input logic cs, input logic st,
                     input logic aw, input logic le, input logic [3:0] lw,
                     input logic [7:0] a, input logic [35:0] d);
    proc_stb_n = ps; ctrl_stb_n = cs; step_n = st;
    all_wr_n = aw; lane_en_n = le; lane_wr_n = lw;
    addr = a; dq_in = d;
    tick();
  endtask

  task automatic idle_read(input logic st);
    cyc(1, 1, st, 1, 1, 4'hF, 8'h00, JUNK);
  endtask

  task automatic t_reset;
    rst = 1; sel_a_n = 0; sel_b_n = 0; sel_c = 1; drive_en_n = 0;
    proc_stb_n = 1; ctrl_stb_n = 1; step_n = 1; all_wr_n = 1; lane_en_n = 1;
    lane_wr_n = 4'hF; addr = 0; dq_in = 0;
    tick(); tick();
    rst = 0;
    tick();
    check("R9 reset leaves no drive", {35'd0, dq_oe}, 36'd0);
  endtask

  task automatic t_burst_write_read;
    cyc(1, 0, 1, 0, 1, 4'hF, 8'h10, D0);
    check("R6 ctrl strobe write same cycle", dq_out, D0);
    check("R9 drive when active", {35'd0, dq_oe}, 36'd1);
    cyc(1, 1, 0, 0, 1, 4'hF, 8'h00, D1);
    check("R10 write to stepped addr", dq_out, D1);
    cyc(1, 1, 0, 0, 1, 4'hF, 8'h00, D2);
    check("R3 step to +2", dq_out, D2);
    cyc(1, 1, 0, 0, 1, 4'hF, 8'h00, D3);
    check("R3 step to +3", dq_out, D3);
    cyc(1, 1, 0, 0, 1, 4'hF, 8'h00, D4);
    check("R3 wrap to base overwrites D0", dq_out, D4);
    cyc(0, 1, 1, 1, 1, 4'hF, 8'h11, JUNK);
    check("R2 flow-through read after proc load", dq_out, D1);
    idle_read(0);
    check("R2 burst read +1", dq_out, D2);
    idle_read(0);
    check("R2 burst read +2", dq_out, D3);
    idle_read(0);
    check("R3 read wraps to aligned base", dq_out, D4);
  endtask

  task automatic t_hold;
    idle_read(1);
    check("R4 hold keeps address", dq_out, D4);
    idle_read(1);
    check("R4 hold second cycle", dq_out, D4);
  endtask

  task automatic t_proc_ignore;
    cyc(0, 1, 1, 0, 0, 4'h0, 8'h12, JUNK);
    check("R5 proc strobe ignores write", dq_out, D2);
    idle_read(1);
    check("R5 no late write after proc load", dq_out, D2);
    cyc(0, 0, 1, 0, 0, 4'h0, 8'h13, JUNK);
    check("R5 proc strobe wins over ctrl", dq_out, D3);
  endtask

  task automatic t_lanes;
    cyc(1, 0, 1, 0, 1, 4'hF, 8'h30, 36'h0);
    check("R7 full write zeros", dq_out, 36'h0);
    cyc(1, 1, 1, 1, 0, 4'b1010, 8'h00, 36'hF_FFFF_FFFF);
    check("R8 lanes 0 and 2 only", dq_out, 36'h0_07FC_01FF);
    cyc(1, 1, 1, 1, 1, 4'h0, 8'h00, 36'h0);
    check("R8 lane enable high blocks write", dq_out, 36'h0_07FC_01FF);
    cyc(1, 1, 1, 1, 0, 4'h0, 8'h00, 36'h5_5555_5555);
    check("R7 all lanes selected gives full write", dq_out, 36'h5_5555_5555);
    cyc(1, 1, 1, 0, 1, 4'hF, 8'h00, 36'hA_AAAA_AAAA);
    check("R7 global write overrides lanes", dq_out, 36'hA_AAAA_AAAA);
  endtask

  task automatic t_restart;
    cyc(1, 0, 1, 0, 1, 4'hF, 8'h40, 36'h0_0000_00E0);
    cyc(1, 1, 0, 0, 1, 4'hF, 8'h00, 36'h0_0000_00E1);
    cyc(1, 0, 1, 0, 1, 4'hF, 8'h50, 36'h0_0000_00F0);
    check("R6 mid-burst restart", dq_out, 36'h0_0000_00F0);
    cyc(1, 1, 0, 0, 1, 4'hF, 8'h00, 36'h0_0000_00F1);
    check("R6 new burst steps from new base", dq_out, 36'h0_0000_00F1);
    cyc(0, 1, 1, 1, 1, 4'hF, 8'h41, JUNK);
    check("R6 old burst word intact", dq_out, 36'h0_0000_00E1);
  endtask

  task automatic t_deselect;
    sel_c = 0;
    cyc(1, 0, 1, 0, 1, 4'hF, 8'h10, JUNK);
    check("R1 deselected strobe no drive", {35'd0, dq_oe}, 36'd0);
    sel_c = 1;
    cyc(1, 1, 0, 0, 1, 4'hF, 8'h00, JUNK);
    check("R1 no write after deselect", {35'd0, dq_oe}, 36'd0);
    sel_b_n = 1;
    cyc(0, 1, 1, 1, 1, 4'hF, 8'h20, JUNK);
    check("R1 second enable deselects", {35'd0, dq_oe}, 36'd0);
    sel_b_n = 0;
    cyc(0, 1, 1, 1, 1, 4'hF, 8'h10, JUNK);
    check("R1 word at 0x10 unchanged", dq_out, D4);
    idle_read(0);
    check("R1 word at 0x11 unchanged", dq_out, D1);
  endtask

  task automatic t_drive;
    drive_en_n = 1;
    #1;
    check("R9 drive enable high forces off", {35'd0, dq_oe}, 36'd0);
    drive_en_n = 0;
    #1;
    check("R9 drive enable low with burst", {35'd0, dq_oe}, 36'd1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_burst_write_read();
    t_hold();
    t_proc_ignore();
    t_lanes();
    t_restart();
    t_deselect();
    t_drive();
    finish_run();
  end
endmodule